// File: doc/BRIEF.md
# Accumulator ALU Execute Stage with Skip Test

This block is the execute stage of a small two-operand accumulator machine. Each cycle it takes a source word, a destination word, the current carry flag and a 16-bit instruction word. From these it computes a result word, a new carry flag, a write enable for the destination register and a request to skip the next instruction. All four outputs are registered, so a result appears one clock after its operands.

The instruction word has five fields. A three-bit function code sets how the source is handled: it can be complemented, incremented and added to the destination, and code 7 is the bitwise AND. A two-bit carry field sets the base carry before the operation. A two-bit shift field can rotate the result through the carry or swap the result's bytes. A no-save bit blocks the destination write. A three-bit skip code tests the final carry and the final result.

The skip test uses the value that would be written, even when the no-save bit blocks the write. This lets software test a value without changing it. Instruction fetch, the register file and memory access are outside this block.

Top module: `acc_alu_exec`

## Requirements
- R1: While rst_n is low, and until the first rising edge after it rises, result_o, carry_o, wr_en_o and skip_o are all 0.
- R2: All four outputs are registered and take their new values at the rising clock edge after the inputs are presented. Function codes insn_i[14:12] = 0..6 give: 0 ~S, 1 -S, 2 S, 3 S+1, 4 D+~S, 5 D-S, 6 D+S.
- R3: Function code 7 gives D AND S and produces no carry out.
- R4: Carry field insn_i[5:4] sets the base carry: 0 keeps carry_i, 1 forces 0, 2 forces 1, 3 complements carry_i. A carry out of bit 15 of the arithmetic complements the base carry.
- R5: Shift field insn_i[7:6] = 1 rotates the 17-bit value {carry, result} left by one. Shift field = 2 rotates it right by one. Shift field = 0 leaves the result unchanged.
- R6: Shift field = 3 swaps the two bytes of the result and leaves the carry unchanged.
- R7: wr_en_o is the inverse of the no-save bit insn_i[3]. result_o and carry_o are produced in the same way whatever the value of that bit.
- R8: Skip code insn_i[2:0] selects a carry test: 0 never skips, 1 always skips, 2 skips when the final carry is 0, 3 skips when the final carry is 1.
- R9: Skip code 4 skips when the final result is zero. Skip code 5 skips when it is nonzero. Both tests apply even when the no-save bit is 1.
- R10: Skip code 6 skips when the carry is 0 or the result is zero. Skip code 7 skips when the carry is 1 and the result is nonzero.
- R11: Instruction bits 15 and 11..8 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 16 | Source operand S |
| dst_i | input | 16 | Destination operand D |
| carry_i | input | 1 | Current carry flag |
| insn_i | input | 16 | Instruction word |
| result_o | output | 16 | Registered result |
| carry_o | output | 1 | Registered new carry |
| wr_en_o | output | 1 | Registered destination write enable |
| skip_o | output | 1 | Registered skip-next request |

## Verification
The bench builds the block with the default width of 16 bits.

At this width the arithmetic corners can be reached directly:
- negating zero and incrementing 0xFFFF, which carry out of the top bit;
- subtracting with and without a borrow;
- a rotate that moves a carry into bit 0 or bit 15;
- a byte swap whose two halves differ.

Directed cases cover each carry preset and each skip code on a zero and a nonzero result. Pseudo-random instructions, with the ignored bits set, then cover combinations of function, preset and shift.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int INSN_W = 16;

  typedef enum logic [1:0] {SH_NONE = 2'd0, SH_ROL = 2'd1, SH_ROR = 2'd2, SH_SWAP = 2'd3} shift_e;
  typedef enum logic [1:0] {CP_KEEP = 2'd0, CP_ZERO = 2'd1, CP_ONE = 2'd2, CP_FLIP = 2'd3} cpre_e;
  typedef enum logic [2:0] {
    SK_NEVER = 3'd0, SK_ALWAYS = 3'd1, SK_CZERO = 3'd2, SK_CSET = 3'd3,
    SK_RZERO = 3'd4, SK_RNZ = 3'd5, SK_EITHER = 3'd6, SK_BOTHNZ = 3'd7
  } skip_e;

  function automatic logic preset_carry(input cpre_e mode, input logic c);
    case (mode)
      CP_KEEP: preset_carry = c;
      CP_ZERO: preset_carry = 1'b0;
      CP_ONE:  preset_carry = 1'b1;
      default: preset_carry = ~c;
    endcase
  endfunction
endpackage

// File: rtl/acc_alu_core.sv
module acc_alu_core #(
  parameter int WIDTH = 16
) (
  input  logic [2:0]       fn,
  input  logic [WIDTH-1:0] src,
  input  logic [WIDTH-1:0] dst,
  input  logic             base_c,
  output logic [WIDTH-1:0] res,
  output logic             c_out
);
  localparam int SW = WIDTH + 1;

  logic [WIDTH-1:0] op_a, op_b;
  logic [SW-1:0]    sum;

  always_comb begin
    op_a = fn[2] ? dst : '0;
    op_b = fn[1] ? src : ~src;
    sum  = {1'b0, op_a} + {1'b0, op_b} + SW'(fn[0]);
    if (fn == 3'b111) begin
      res   = dst & src;
      c_out = base_c;
    end else begin
      res   = sum[WIDTH-1:0];
      c_out = base_c ^ sum[WIDTH];
    end
  end
endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  shift_e           mode,
  input  logic [WIDTH-1:0] d_in,
  input  logic             c_in,
  output logic [WIDTH-1:0] d_out,
  output logic             c_out
);
  localparam int HALF = WIDTH / 2;

  always_comb begin
    d_out = d_in;
    c_out = c_in;
    case (mode)
      SH_ROL: begin
        d_out = {d_in[WIDTH-2:0], c_in};
        c_out = d_in[WIDTH-1];
      end
      SH_ROR: begin
        d_out = {c_in, d_in[WIDTH-1:1]};
        c_out = d_in[0];
      end
      SH_SWAP: d_out = {d_in[HALF-1:0], d_in[WIDTH-1:HALF]};
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_skip.sv
module acc_alu_skip
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  skip_e            code,
  input  logic [WIDTH-1:0] value,
  input  logic             carry,
  output logic             skip
);
  logic is_zero;

  always_comb begin
    is_zero = (value == '0);
    case (code)
      SK_NEVER:  skip = 1'b0;
      SK_ALWAYS: skip = 1'b1;
      SK_CZERO:  skip = ~carry;
      SK_CSET:   skip = carry;
      SK_RZERO:  skip = is_zero;
      SK_RNZ:    skip = ~is_zero;
      SK_EITHER: skip = ~carry | is_zero;
      default:   skip = carry & ~is_zero;
    endcase
  end
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  src_i,
  input  logic [WIDTH-1:0]  dst_i,
  input  logic              carry_i,
  input  logic [INSN_W-1:0] insn_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              carry_o,
  output logic              wr_en_o,
  output logic              skip_o
);
  logic [2:0] fn_f;
  shift_e     sh_f;
  cpre_e      cp_f;
  logic       nosave_f;
  skip_e      sk_f;
  logic       unused_bits;

  assign fn_f        = insn_i[14:12];
  assign sh_f        = shift_e'(insn_i[7:6]);
  assign cp_f        = cpre_e'(insn_i[5:4]);
  assign nosave_f    = insn_i[3];
  assign sk_f        = skip_e'(insn_i[2:0]);
  assign unused_bits = ^{insn_i[15], insn_i[11:8]};

  logic             base_c;
  logic [WIDTH-1:0] alu_res, sh_res;
  logic             alu_c, sh_c, skip_n;

  assign base_c = preset_carry(cp_f, carry_i);

  acc_alu_core #(.WIDTH(WIDTH)) u_core (
    .fn(fn_f), .src(src_i), .dst(dst_i), .base_c(base_c), .res(alu_res), .c_out(alu_c)
  );

  acc_alu_shift #(.WIDTH(WIDTH)) u_shift (
    .mode(sh_f), .d_in(alu_res), .c_in(alu_c), .d_out(sh_res), .c_out(sh_c)
  );

  acc_alu_skip #(.WIDTH(WIDTH)) u_skip (
    .code(sk_f), .value(sh_res), .carry(sh_c), .skip(skip_n)
  );

  logic live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o <= '0;
      carry_o  <= 1'b0;
      wr_en_o  <= 1'b0;
      skip_o   <= 1'b0;
      live_q   <= 1'b0;
    end else begin
      result_o <= sh_res;
      carry_o  <= sh_c;
      wr_en_o  <= ~nosave_f;
      skip_o   <= skip_n;
      live_q   <= 1'b1;
    end
  end

  p_and_no_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_f == 3'b111) |-> (alu_c == base_c));

  p_rol_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_f == SH_ROL) |-> (sh_c == alu_res[WIDTH-1] && sh_res[0] == alu_c));

  p_swap_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_f == SH_SWAP) |-> (sh_c == alu_c));

  p_wr_nosave_r7: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (wr_en_o == !$past(nosave_f)));

  p_zero_skip_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_f == SK_RZERO) |-> (skip_n == (sh_res == '0)));

  p_both_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sk_f == SK_BOTHNZ) |-> (skip_n == (sh_c && sh_res != '0)));
endmodule

// File: tb/tb_acc_alu_exec.sv
`timescale 1ns/1ps
module tb_acc_alu_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src_i = '0, dst_i = '0, insn_i = '0;
  logic        carry_i = 1'b0;
  logic [15:0] result_o;
  logic        carry_o, wr_en_o, skip_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  acc_alu_exec dut (
    .clk(clk), .rst_n(rst_n), .src_i(src_i), .dst_i(dst_i), .carry_i(carry_i),
    .insn_i(insn_i), .result_o(result_o), .carry_o(carry_o), .wr_en_o(wr_en_o),
    .skip_o(skip_o)
  );

  typedef struct {
    logic [15:0] r;
    logic        c;
    logic        w;
    logic        k;
    string       tag;
  } exp_t;

  exp_t sb[$];

  function automatic logic [15:0] mk(input int fn, input int sh, input int cp,
                                     input int ns, input int sk);
    mk = {1'b0, 3'(fn), 4'b0, 2'(sh), 2'(cp), 1'(ns), 3'(sk)};
  endfunction

  function automatic exp_t model(input logic [15:0] s, input logic [15:0] d,
                                 input logic c, input logic [15:0] ins, input string tag);
    exp_t e;
    logic        bc, co, cy;
    logic [15:0] r;
    logic [16:0] t;
    case (ins[5:4])
      2'd0: bc = c;
      2'd1: bc = 1'b0;
      2'd2: bc = 1'b1;
      default: bc = !c;
    endcase
    case (ins[14:12])
      3'd0: t = {1'b0, ~s};
      3'd1: t = 17'h10000 - {1'b0, s};
      3'd2: t = {1'b0, s};
      3'd3: t = {1'b0, s} + 17'd1;
      3'd4: t = {1'b0, d} + {1'b0, ~s};
      3'd5: t = {1'b0, d} + 17'h10000 - {1'b0, s};
      3'd6: t = {1'b0, d} + {1'b0, s};
      default: t = {1'b0, d & s};
    endcase
    co = t[16];
    r  = t[15:0];
    cy = bc ^ co;
    t  = {cy, r};
    case (ins[7:6])
      2'd1: t = {t[15:0], t[16]};
      2'd2: t = {t[0], t[16:1]};
      2'd3: t = {t[16], t[7:0], t[15:8]};
      default: ;
    endcase
    cy = t[16];
    r  = t[15:0];
    case (ins[2:0])
      3'd0: e.k = 1'b0;
      3'd1: e.k = 1'b1;
      3'd2: e.k = (cy == 1'b0);
      3'd3: e.k = (cy == 1'b1);
      3'd4: e.k = (r == 16'h0);
      3'd5: e.k = (r != 16'h0);
      3'd6: e.k = (cy == 1'b0) || (r == 16'h0);
      default: e.k = (cy == 1'b1) && (r != 16'h0);
    endcase
    e.r = r;
    e.c = cy;
    e.w = !ins[3];
    e.tag = tag;
    return e;
  endfunction

  task automatic drive(input logic [15:0] s, input logic [15:0] d, input logic c,
                       input logic [15:0] ins, input string tag);
    @(negedge clk);
    src_i = s;
    dst_i = d;
    carry_i = c;
    insn_i = ins;
    sb.push_back(model(s, d, c, ins, tag));
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (result_o !== e.r || carry_o !== e.c || wr_en_o !== e.w || skip_o !== e.k) begin
        errors++;
        $display("FAIL %s: got r=%h c=%b w=%b k=%b expected r=%h c=%b w=%b k=%b",
                 e.tag, result_o, carry_o, wr_en_o, skip_o, e.r, e.c, e.w, e.k);
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    src_i = 16'hFFFF;
    dst_i = 16'h1234;
    carry_i = 1'b1;
    insn_i = mk(6, 1, 2, 0, 1);
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (result_o !== 16'h0 || carry_o !== 1'b0 || wr_en_o !== 1'b0 || skip_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: got r=%h c=%b w=%b k=%b expected all zero",
               result_o, carry_o, wr_en_o, skip_o);
    end
    @(negedge clk);
    rst_n = 1'b1;

    // R2 basic functions
    drive(16'h00F0, 16'h0000, 1'b0, mk(0, 0, 0, 0, 0), "R2 com");
    drive(16'h0001, 16'h0000, 1'b0, mk(1, 0, 0, 0, 0), "R2 neg one");
    drive(16'h0000, 16'h0000, 1'b0, mk(1, 0, 0, 0, 0), "R2 neg zero carries");
    drive(16'hBEEF, 16'h1111, 1'b1, mk(2, 0, 0, 0, 0), "R2 mov");
    drive(16'hFFFF, 16'h0000, 1'b0, mk(3, 0, 0, 0, 0), "R2 inc wrap");
    drive(16'h0003, 16'h0005, 1'b0, mk(4, 0, 0, 0, 0), "R2 adc");
    drive(16'h0003, 16'h0005, 1'b0, mk(5, 0, 0, 0, 0), "R2 sub no borrow");
    drive(16'h0005, 16'h0003, 1'b0, mk(5, 0, 0, 0, 0), "R2 sub borrow");
    drive(16'h8001, 16'h8002, 1'b0, mk(6, 0, 0, 0, 0), "R2 add carry");
    // R3 and
    drive(16'hF0F0, 16'hFF00, 1'b1, mk(7, 0, 0, 0, 0), "R3 and");
    // R4 presets
    drive(16'h0001, 16'h0001, 1'b1, mk(6, 0, 0, 0, 0), "R4 keep");
    drive(16'h0001, 16'h0001, 1'b1, mk(6, 0, 1, 0, 0), "R4 zero");
    drive(16'h0001, 16'h0001, 1'b0, mk(6, 0, 2, 0, 0), "R4 one");
    drive(16'hFFFF, 16'h0001, 1'b1, mk(6, 0, 3, 0, 0), "R4 flip with carry out");
    // R5 rotates
    drive(16'h8001, 16'h0, 1'b0, mk(2, 1, 2, 0, 0), "R5 rol");
    drive(16'h8001, 16'h0, 1'b0, mk(2, 2, 1, 0, 0), "R5 ror");
    // R6 swap
    drive(16'h12AB, 16'h0, 1'b1, mk(2, 3, 0, 0, 0), "R6 swap");
    drive(16'hFFFF, 16'h0001, 1'b0, mk(6, 3, 0, 0, 0), "R6 swap after carry");
    // R7 nosave
    drive(16'h4321, 16'h0, 1'b0, mk(2, 0, 0, 1, 0), "R7 nosave");
    // R8 carry skips
    drive(16'h0001, 16'h0, 1'b0, mk(2, 0, 0, 0, 1), "R8 always");
    drive(16'h0001, 16'h0, 1'b0, mk(2, 0, 1, 0, 2), "R8 carry zero");
    drive(16'h0001, 16'h0, 1'b0, mk(2, 0, 1, 0, 3), "R8 carry set no");
    drive(16'h0001, 16'h0, 1'b0, mk(2, 0, 2, 0, 3), "R8 carry set yes");
    // R9 result skips, including nosave
    drive(16'h0000, 16'h0, 1'b0, mk(2, 0, 0, 1, 4), "R9 zero nosave");
    drive(16'h0007, 16'h0, 1'b0, mk(2, 0, 0, 0, 4), "R9 zero no");
    drive(16'h0007, 16'h0, 1'b0, mk(2, 0, 0, 1, 5), "R9 nonzero nosave");
    // R10 combined
    drive(16'h0007, 16'h0, 1'b0, mk(2, 0, 2, 0, 6), "R10 either no");
    drive(16'h0000, 16'h0, 1'b0, mk(2, 0, 2, 0, 6), "R10 either yes");
    drive(16'h0007, 16'h0, 1'b0, mk(2, 0, 2, 0, 7), "R10 both yes");
    drive(16'h0007, 16'h0, 1'b0, mk(2, 0, 1, 0, 7), "R10 both no");
    // R11 ignored bits
    drive(16'h00FF, 16'h0F0F, 1'b1, mk(6, 1, 0, 0, 5) | 16'h8F00, "R11 ignored bits");

    lf = 32'h1ACE_B00C;
    for (int i = 0; i < 300; i++) begin
      logic [15:0] s, d, ins;
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      s = lf[15:0];
      d = lf[31:16];
      lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
      ins = lf[15:0];
      if (i % 7 == 0) s = 16'h0000;
      drive(s, d, lf[20], ins, "R2 random");
    end

    @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule